// File: doc/BRIEF.md
# Quad DAC Two-Rank Code Register Interface

This block is the digital front end of a four-channel digital-to-analog converter, modelled synchronously. A host drives a parallel bus made of active-low strobes (chip select, read, load, transfer, mode select, clear), a group-select field that must match for the device to respond, a two-bit channel address, and a 12-bit data word. Each channel has two latch ranks. The first rank takes new codes from the bus. The second rank drives the converter code on `dac_code`. A separate mode register holds a control word.

In normal operation the host loads first-rank latches one channel at a time. A single transfer strobe then updates all four converter codes in the same cycle. Two pass-through modes skip the staging step. One writes the same data into both ranks of all channels. The other writes both ranks of only the addressed channel, and it still works when the transfer strobe is tied low. Channel codes and the mode word can be read back. Writes and reads can cover a 4-bit, 8-bit or 12-bit slice of a word.

The host bus is a plain strobe interface with no valid/ready handshake and no back-pressure. Every command is taken in the clock cycle in which it is sampled. The data return is split into `rdata`, `rdata_oe` and `wdata`. Pad logic outside the block combines them into one shared bus.

Top module: `qdac_regif`

## Requirements
- R1: While `rst_n` is low, or in any cycle where `clr_n` is sampled low, both ranks of every channel become zero and the mode register becomes `MODE_RST` (default 8'h3C). `clr_n` low overrides every other strobe.
- R2: A load (`cs_n`=0, `quad_n`=0, `ld_n`=0, `xfer_n`=1, `msel_n`=1, `rd_n`=1) updates only the first rank of the channel named by `chan_sel`. `dac_code` does not change.
- R3: A transfer (`cs_n`=1, `xfer_n`=0) copies all four first-rank latches into the second rank in the same cycle.
- R4: A broadcast pass-through (`cs_n`=0, `quad_n`=0, `xfer_n`=0, `ld_n`=1, `msel_n`=1, `rd_n`=1) writes the merged word into both ranks of all four channels.
- R5: A single-channel pass-through (`cs_n`=0, `quad_n`=0, `xfer_n`=0, `ld_n`=0, `msel_n`=1, `rd_n`=1) writes both ranks of the addressed channel only. This also holds when `xfer_n` stays low between commands.
- R6: The slice encoding is as follows. `wid_sel` 0 covers one nibble, 1 covers two nibbles, and 2 or 3 covers all three. `part_sel` is the nibble offset of the slice. On a write, data nibble j replaces stored nibble j+`part_sel` for j below the span; nibbles past bit 11 are dropped. On a read, stored nibble j+`part_sel` is returned on data nibble j, and all other data bits read zero.
- R7: A code read (`cs_n`=0, `rd_n`=0, `quad_n`=0, `msel_n`=1) raises `rdata_oe` one cycle later. `rdata` then carries the first-rank code of the addressed channel.
- R8: A mode write (`cs_n`=0, `quad_n`=0, `msel_n`=0, `rd_n`=1) stores `wdata[7:0]`. A mode read (`cs_n`=0, `rd_n`=0, `quad_n`=0, `msel_n`=0, `xfer_n`=1) returns it, zero-extended, with the R6 slicing and the R7 timing.
- R9: Once the read condition ends, `rdata_oe` drops on the next clock edge and `rdata` reads zero.
- R10: When `cs_n` and `rd_n` are both low, no latch and no mode bit changes, whatever the load, transfer and mode strobes do.
- R11: When `quad_n` is not all zero, a command with `cs_n` low changes nothing and does not raise `rdata_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous system reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| ld_n | input | 1 | Load strobe for the addressed channel, active low |
| xfer_n | input | 1 | Rank transfer strobe, active low |
| msel_n | input | 1 | Mode register select, active low |
| clr_n | input | 1 | Bus clear, active low, synchronous |
| quad_n | input | 3 | Group select; all bits low selects this device |
| chan_sel | input | 2 | Channel address |
| wid_sel | input | 2 | Access width: 0 = 4 bits, 1 = 8 bits, 2/3 = 12 bits |
| part_sel | input | 2 | Nibble offset of a narrow access |
| wdata | input | 12 | Write data from the host |
| rdata | output | 12 | Read-back data |
| rdata_oe | output | 1 | Drive enable for the shared data bus |
| dac_code | output | 48 | Second-rank codes, channel i at bits 12i+11:12i |

## Verification
The hardest state to reach is a transfer strobe held permanently low. Every idle cycle then becomes a rank copy, so each pass-through write competes with a copy in the cycles around it. The bench has a phase in which its idle bus keeps `xfer_n` low and runs single-channel pass-through writes back to back, with staged first-rank values left behind from earlier loads. Its model applies a copy before each command and then checks that the converter codes match. Read-versus-write collisions are driven by asserting the load, transfer or mode strobes together with a read. The bench then reads the targets back to show that nothing moved.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  typedef enum logic [3:0] {
    OP_IDLE,
    OP_CLEAR,
    OP_LOAD,
    OP_XFER,
    OP_FULL,
    OP_PART,
    OP_MODEW,
    OP_RDCODE,
    OP_RDMODE
  } op_e;

  // number of nibbles an access covers (R6)
  function automatic int span_of(input logic [1:0] wsel, input int full);
    int n;
    case (wsel)
      2'd0:    n = 1;
      2'd1:    n = 2;
      default: n = full;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/qdac_decode.sv
module qdac_decode #(
  parameter int QW = 3
) (
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          ld_n,
  input  logic          xfer_n,
  input  logic          msel_n,
  input  logic          clr_n,
  input  logic [QW-1:0] quad_n,
  output qdac_pkg::op_e op
);
  import qdac_pkg::*;

  logic picked;
  assign picked = !cs_n && (quad_n == '0);

  always_comb begin
    op = OP_IDLE;
    if (!clr_n) begin
      op = OP_CLEAR;
    end else if (!cs_n && !rd_n) begin
      // read owns the cycle (R10); foreign group does nothing (R11)
      if (picked) begin
        if (msel_n)      op = OP_RDCODE;
        else if (xfer_n) op = OP_RDMODE;
      end
    end else if (picked && !msel_n) begin
      op = OP_MODEW;
    end else if (picked && !xfer_n) begin
      op = ld_n ? OP_FULL : OP_PART;
    end else if (picked && !ld_n) begin
      op = OP_LOAD;
    end else if (cs_n && !xfer_n) begin
      op = OP_XFER;
    end
  end

endmodule

// File: rtl/qdac_chan.sv
module qdac_chan #(
  parameter int W  = 12,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load_en,
  input  logic          pass_en,
  input  logic          copy_en,
  input  logic [W-1:0]  wdata,
  input  logic [1:0]    wsel,
  input  logic [PW-1:0] psel,
  output logic [W-1:0]  first_q,
  output logic [W-1:0]  second_q
);
  localparam int NIB = W / 4;

  function automatic logic [W-1:0] merge(input logic [W-1:0] old,
                                         input logic [W-1:0] d,
                                         input int span, input int off);
    logic [W-1:0] r;
    r = old;
    for (int j = 0; j < NIB; j++) begin
      if (j < span && (j + off) < NIB) r[4*(j+off) +: 4] = d[4*j +: 4];
    end
    return r;
  endfunction

  logic [W-1:0] merged;
  assign merged = merge(first_q, wdata, qdac_pkg::span_of(wsel, NIB), int'(psel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q  <= '0;
      second_q <= '0;
    end else if (clear) begin
      first_q  <= '0;
      second_q <= '0;
    end else begin
      if (load_en || pass_en) first_q <= merged;
      if (pass_en)            second_q <= merged;
      else if (copy_en)       second_q <= first_q;
    end
  end

  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (first_q == '0 && second_q == '0));

  p_copy_rank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_en && !pass_en && !clear) |=> second_q == $past(first_q));

  p_pass_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_en && !clear) |=> second_q == first_q);

  p_hold_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_en || copy_en || clear) |=> $stable(second_q));

endmodule

// File: rtl/qdac_rdmux.sv
module qdac_rdmux #(
  parameter int W      = 12,
  parameter int PW     = 2,
  parameter int MODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_code,
  input  logic              rd_mode,
  input  logic [W-1:0]      code_in,
  input  logic [MODE_W-1:0] mode_in,
  input  logic [1:0]        wsel,
  input  logic [PW-1:0]     psel,
  output logic [W-1:0]      rdata,
  output logic              rdata_oe
);
  localparam int NIB = W / 4;

  function automatic logic [W-1:0] pick(input logic [W-1:0] src,
                                        input int span, input int off);
    logic [W-1:0] r;
    r = '0;
    for (int j = 0; j < NIB; j++) begin
      if (j < span && (j + off) < NIB) r[4*j +: 4] = src[4*(j+off) +: 4];
    end
    return r;
  endfunction

  logic [W-1:0] src;
  int           span;
  assign src  = rd_mode ? W'(mode_in) : code_in;
  assign span = qdac_pkg::span_of(wsel, NIB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rdata_oe <= 1'b0;
    end else begin
      rdata_oe <= rd_code || rd_mode;
      rdata    <= (rd_code || rd_mode) ? pick(src, span, int'(psel)) : '0;
    end
  end

  p_oe_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_code || rd_mode) |=> rdata_oe);

  p_oe_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_code || rd_mode) |=> (!rdata_oe && rdata == '0));

endmodule

// File: rtl/qdac_regif.sv
module qdac_regif #(
  parameter int              W        = 12,
  parameter int              NCH      = 4,
  parameter int              QW       = 3,
  parameter int              MODE_W   = 8,
  parameter logic [MODE_W-1:0] MODE_RST = 8'h3C,
  localparam int             CH_AW    = $clog2(NCH),
  localparam int             PW       = $clog2(W / 4)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             ld_n,
  input  logic             xfer_n,
  input  logic             msel_n,
  input  logic             clr_n,
  input  logic [QW-1:0]    quad_n,
  input  logic [CH_AW-1:0] chan_sel,
  input  logic [1:0]       wid_sel,
  input  logic [PW-1:0]    part_sel,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  output logic             rdata_oe,
  output logic [NCH*W-1:0] dac_code
);
  import qdac_pkg::*;

  op_e               op;
  logic [MODE_W-1:0] mode_q;
  logic [W-1:0]      first_a  [NCH];
  logic [W-1:0]      second_a [NCH];
  logic              clear;

  qdac_decode #(.QW(QW)) u_dec (
    .cs_n(cs_n), .rd_n(rd_n), .ld_n(ld_n), .xfer_n(xfer_n),
    .msel_n(msel_n), .clr_n(clr_n), .quad_n(quad_n), .op(op)
  );

  assign clear = (op == OP_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              mode_q <= MODE_RST;
    else if (clear)          mode_q <= MODE_RST;
    else if (op == OP_MODEW) mode_q <= wdata[MODE_W-1:0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = (chan_sel == CH_AW'(i));

    qdac_chan #(.W(W), .PW(PW)) u_ch (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .load_en(op == OP_LOAD && hit),
      .pass_en(op == OP_FULL || (op == OP_PART && hit)),
      .copy_en(op == OP_XFER),
      .wdata(wdata), .wsel(wid_sel), .psel(part_sel),
      .first_q(first_a[i]), .second_q(second_a[i])
    );

    assign dac_code[i*W +: W] = second_a[i];
  end

  qdac_rdmux #(.W(W), .PW(PW), .MODE_W(MODE_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .rd_code(op == OP_RDCODE), .rd_mode(op == OP_RDMODE),
    .code_in(first_a[chan_sel]), .mode_in(mode_q),
    .wsel(wid_sel), .psel(part_sel),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  p_read_blocks_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rd_n && clr_n) |=> ($stable(dac_code) && $stable(mode_q)));

  p_foreign_group_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && quad_n != '0 && clr_n) |=> ($stable(dac_code) && $stable(mode_q)));

  p_load_keeps_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && quad_n == '0 && !ld_n && xfer_n && msel_n && rd_n && clr_n)
      |=> $stable(dac_code));

  p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !(!cs_n && quad_n == '0 && !msel_n && rd_n)) |=> $stable(mode_q));

endmodule

// File: tb/tb_qdac_regif.sv
module tb_qdac_regif;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam logic [7:0] MODE_DEFAULT = 8'h3C;

  logic clk = 1'b0;
  logic rst_n, cs_n, rd_n, ld_n, xfer_n, msel_n, clr_n;
  logic [2:0] quad_n;
  logic [1:0] chan_sel, wid_sel, part_sel;
  logic [W-1:0] wdata, rdata;
  logic rdata_oe;
  logic [4*W-1:0] dac_code;

  qdac_regif dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .ld_n(ld_n),
    .xfer_n(xfer_n), .msel_n(msel_n), .clr_n(clr_n), .quad_n(quad_n),
    .chan_sel(chan_sel), .wid_sel(wid_sel), .part_sel(part_sel),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .dac_code(dac_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 0;
  bit hold_low = 0;

  logic [W-1:0] m_first [4];
  logic [W-1:0] m_second [4];
  logic [7:0]   m_mode;

  logic [W-1:0] exp_q [$];
  string        tag_q [$];

  function automatic int span(input logic [1:0] w);
    return (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 3;
  endfunction

  // bitwise write model (R6)
  function automatic logic [W-1:0] put(input logic [W-1:0] old, input logic [W-1:0] d,
                                       input logic [1:0] w, input logic [1:0] p);
    logic [W-1:0] r = old;
    for (int b = 0; b < W; b++) begin
      int nb = b / 4;
      if (nb >= p && nb < p + span(w)) r[b] = d[b - 4*p];
    end
    return r;
  endfunction

  // bitwise read model (R6)
  function automatic logic [W-1:0] get(input logic [W-1:0] src,
                                       input logic [1:0] w, input logic [1:0] p);
    logic [W-1:0] r = '0;
    for (int b = 0; b < W; b++) begin
      if (b / 4 < span(w) && b + 4*p < W) r[b] = src[b + 4*p];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [4*W-1:0] act,
                       input logic [4*W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_codes(input string req);
    logic [4*W-1:0] e;
    for (int c = 0; c < 4; c++) e[c*W +: W] = m_second[c];
    check(dac_code === e, req, dac_code, e);
  endtask

  task automatic idle_bus();
    cs_n = 1; rd_n = 1; ld_n = 1; msel_n = 1; clr_n = 1;
    xfer_n = hold_low ? 1'b0 : 1'b1;
    quad_n = '0;
  endtask

  task automatic drive(input logic cs, rd, ld, xf, ms, cl, input logic [2:0] q,
                       input logic [1:0] ch, w, p, input logic [W-1:0] d);
    @(negedge clk);
    if (hold_low) for (int c = 0; c < 4; c++) m_second[c] = m_first[c];
    cs_n = cs; rd_n = rd; ld_n = ld; xfer_n = xf; msel_n = ms; clr_n = cl;
    quad_n = q; chan_sel = ch; wid_sel = w; part_sel = p; wdata = d;
    @(negedge clk);
    idle_bus();
  endtask

  task automatic do_load(input logic [1:0] ch, w, p, input logic [W-1:0] d);
    drive(0, 1, 0, 1, 1, 1, 3'b000, ch, w, p, d);
    m_first[ch] = put(m_first[ch], d, w, p);
    check_codes("R2 load leaves outputs");
  endtask

  task automatic do_xfer();
    drive(1, 1, 1, 0, 1, 1, 3'b000, 2'd0, 2'd2, 2'd0, '0);
    for (int c = 0; c < 4; c++) m_second[c] = m_first[c];
    check_codes("R3 transfer");
  endtask

  task automatic do_full(input logic [1:0] w, p, input logic [W-1:0] d);
    drive(0, 1, 1, 0, 1, 1, 3'b000, 2'd3, w, p, d);
    for (int c = 0; c < 4; c++) begin
      m_first[c] = put(m_first[c], d, w, p);
      m_second[c] = m_first[c];
    end
    check_codes("R4 broadcast pass-through");
  endtask

  task automatic do_part(input logic [1:0] ch, w, p, input logic [W-1:0] d);
    drive(0, 1, 0, 0, 1, 1, 3'b000, ch, w, p, d);
    m_first[ch] = put(m_first[ch], d, w, p);
    m_second[ch] = m_first[ch];
    check_codes("R5 single-channel pass-through");
  endtask

  task automatic do_read(input bit mode, input logic [1:0] ch, w, p, input string req);
    exp_q.push_back(get(mode ? W'(m_mode) : m_first[ch], w, p));
    tag_q.push_back(req);
    drive(0, 0, 1, 1, mode ? 1'b0 : 1'b1, 1, 3'b000, ch, w, p, '0);
    @(negedge clk);
    check(!rdata_oe && rdata == '0, "R9 bus release", {rdata_oe, rdata}, '0);
  endtask

  // monitor: pops one expected value per driven read cycle
  always @(negedge clk) begin
    if (rst_n && rdata_oe) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fails++;
        $display("FAIL R7 or R11 unexpected drive actual=%h expected=none", rdata);
      end else begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_fails++;
          $display("FAIL %s actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    rst_n = 0; chan_sel = 0; wid_sel = 2; part_sel = 0; wdata = 0;
    idle_bus();
    for (int c = 0; c < 4; c++) begin m_first[c] = '0; m_second[c] = '0; end
    m_mode = MODE_DEFAULT;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_codes("R1 reset codes");
    check(!rdata_oe, "R1 reset bus idle", rdata_oe, 0);
    do_read(1, 0, 2, 0, "R1 reset mode word");
    do_read(0, 0, 2, 0, "R1 reset first rank");

    do_load(1, 2, 0, 12'hABC);
    do_read(0, 1, 2, 0, "R7 code read ch1");
    do_read(0, 0, 2, 0, "R2 other channel untouched");
    do_load(2, 0, 1, 12'h00F);
    do_load(2, 1, 1, 12'h05A);
    do_read(0, 2, 0, 2, "R6 nibble read at offset 2");
    do_read(0, 2, 1, 0, "R6 byte read at offset 0");
    do_load(3, 2, 2, 12'h0D7);
    do_read(0, 3, 2, 0, "R6 clipped wide write");
    do_xfer();

    drive(0, 1, 1, 1, 0, 1, 3'b000, 0, 2, 0, 12'h196);
    m_mode = 8'h96;
    do_read(1, 0, 2, 0, "R8 mode read full");
    do_read(1, 0, 0, 1, "R8 mode read nibble");

    // read with write strobes asserted (R10)
    exp_q.push_back(get(m_first[0], 2, 0)); tag_q.push_back("R10 read wins over load");
    drive(0, 0, 0, 0, 1, 1, 3'b000, 0, 2, 0, 12'hFFF);
    check_codes("R10 outputs unchanged");
    exp_q.push_back(W'(m_mode)); tag_q.push_back("R10 read wins over mode write");
    drive(0, 0, 1, 1, 0, 1, 3'b000, 0, 2, 0, 12'h011);
    do_read(1, 0, 2, 0, "R10 mode unchanged");
    do_read(0, 0, 2, 0, "R10 first rank unchanged");

    // foreign group (R11)
    drive(0, 1, 0, 1, 1, 1, 3'b010, 0, 2, 0, 12'h555);
    drive(0, 1, 1, 0, 1, 1, 3'b001, 0, 2, 0, 12'h555);
    check_codes("R11 foreign pass-through ignored");
    drive(0, 0, 1, 1, 1, 1, 3'b100, 1, 2, 0, '0);
    check(!rdata_oe, "R11 foreign read not driven", rdata_oe, 0);
    do_read(0, 0, 2, 0, "R11 foreign load ignored");

    do_load(1, 2, 0, 12'h321);
    do_full(0, 0, 12'h009);
    do_read(0, 2, 2, 0, "R4 first rank after broadcast");
    do_load(0, 2, 0, 12'hEEE);
    do_part(3, 2, 0, 12'h777);

    // transfer strobe held low (R5)
    hold_low = 1;
    idle_bus();
    do_load(2, 2, 0, 12'h000);
    do_part(1, 1, 0, 12'h0E1);
    do_part(2, 0, 2, 12'h004);
    hold_low = 0;
    idle_bus();

    drive(1, 1, 1, 1, 1, 0, 3'b000, 0, 2, 0, '0);
    for (int c = 0; c < 4; c++) begin m_first[c] = '0; m_second[c] = '0; end
    m_mode = MODE_DEFAULT;
    check_codes("R1 bus clear");
    do_read(1, 0, 2, 0, "R1 mode after clear");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R7 all reads returned", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule